// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate unit. On every clock edge where the valid strobe is high, it forms the product of an 8-bit multiplicand and an 8-bit multiplier. It adds that product to the running 16-bit total held in its accumulator register. A mode input selects whether the operands are read as two's complement or as unsigned numbers. A synchronous clear returns the total to zero.

The multiplier is recoded in radix 4. Each overlapping three-bit window of the multiplier chooses one of five multiples of the multiplicand: zero, plus or minus once, or plus or minus twice. This gives one partial product per pair of multiplier bits, plus one extra partial product that absorbs the extension bit. A negative multiple is formed as the bitwise inverse of the positive multiple, with a separate +1 injected at that digit's lowest weight. The partial products, the row of injected +1 bits and the current accumulator value all enter one carry-save reduction tree. A single carry-propagate adder at the end resolves the sum and carry rows into the next accumulator value.

The unit is meant for filter and dot-product loops. The caller clears the total, streams operand pairs with the strobe raised, and reads the total from the output one edge after the last pair.

Top module: `booth_mac`

## Requirements
- R1: On a rising clock edge with `in_valid` high and `clr` low, `acc_out` becomes the previous `acc_out` plus `x`·`y`, modulo 2^16. For example, from zero with x=2 and y=4, `acc_out` reads 8.
- R2: With `is_signed` high, both `x` and `y` are read as two's complement values in the range −128..127. For example, −128·−128 adds 16384 and −128·127 adds −16256.
- R3: With `is_signed` low, both `x` and `y` are read as unsigned values in the range 0..255. For example, 255·255 adds 65025.
- R4: Each three-bit window of the multiplier selects a multiple of the multiplicand by the weight −2·top + middle + bottom: 000 and 111 select 0, 001 and 010 select +1, 011 selects +2, 100 selects −2, and 101 and 110 select −1. The bit below multiplier bit 0 is 0. Every multiplier bit pattern must therefore give the exact product.
- R5: On a rising edge with `clr` high, `acc_out` becomes 0, whatever the value of `in_valid`.
- R6: On a rising edge with both `clr` and `in_valid` low, `acc_out` keeps its value, whatever the operands and mode.
- R7: While `rst_n` is low, `acc_out` is 0. It stays 0 after release until an operation is accepted.
- R8: The total wraps modulo 2^16 with no saturation. For example, 65025 + 65025 reads 64514.
- R9: An accepted operation with `x` or `y` equal to zero leaves `acc_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the total, takes priority over in_valid |
| in_valid | input | 1 | Accept x and y on this edge |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| x | input | 8 | Multiplicand |
| y | input | 8 | Multiplier, recoded in radix 4 |
| acc_out | output | 16 | Accumulated total |

## Verification
The path from operands through recoding, the carry-save tree and the final adder is combinational. Every result therefore lands in `acc_out` at the first rising edge after the inputs are applied: one cycle of latency for accumulation, clear and hold alike. The bench drives inputs at the falling edge. It updates its own reference total in the same step, waits for the next rising edge, and compares a short delay after it, so each comparison sees exactly one edge's worth of change. The bound checker states the same one-edge relation through `$past` of the operands and the previous total.

// File: rtl/booth_mac_pkg.sv
`timescale 1ns/1ps
package booth_mac_pkg;

   // selection of one radix-4 digit: sign and magnitude (1x or 2x)
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_sel_t;

   // triplet = {upper, middle, lower} multiplier bits
   function automatic booth_sel_t booth_recode(input logic [2:0] trip);
      booth_sel_t s;
      s.one = trip[1] ^ trip[0];
      s.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
      s.neg = trip[2] & ~(trip[1] & trip[0]);
      return s;
   endfunction

endpackage

// File: rtl/booth_recoder.sv
`timescale 1ns/1ps
module booth_recoder
   import booth_mac_pkg::*;
#(
   parameter int OPW  = 8,
   parameter int NDIG = OPW/2 + 1
) (
   input  logic [OPW-1:0] mplier,
   input  logic           is_signed,
   output booth_sel_t     sel [NDIG]
);

   localparam int EXTW = 2*NDIG + 1;

   logic           ext_bit;
   logic [EXTW-1:0] ext;

   // sign or zero extension, with an implicit 0 below bit 0
   assign ext_bit = is_signed & mplier[OPW-1];
   assign ext     = {{(EXTW-OPW-1){ext_bit}}, mplier, 1'b0};

   for (genvar k = 0; k < NDIG; k++) begin : g_digit
      assign sel[k] = booth_recode(ext[2*k+2 : 2*k]);
   end

endmodule

// File: rtl/booth_pp_row.sv
`timescale 1ns/1ps
module booth_pp_row
   import booth_mac_pkg::*;
#(
   parameter int ACCW  = 16,
   parameter int SHIFT = 0
) (
   input  logic [ACCW-1:0] mcand,
   input  booth_sel_t      sel,
   output logic [ACCW-1:0] row
);

   logic [ACCW-1:0] mag;
   logic [ACCW-1:0] inv;

   always_comb begin
      if (sel.two)
         mag = mcand << 1;
      else if (sel.one)
         mag = mcand;
      else
         mag = '0;
      inv = mag ^ {ACCW{sel.neg}};
      row = inv << SHIFT;
   end

endmodule

// File: rtl/csa_reduce.sv
`timescale 1ns/1ps
module csa_reduce #(
   parameter int W = 16,
   parameter int N = 7
) (
   input  logic [W-1:0] rows [N],
   output logic [W-1:0] sum,
   output logic [W-1:0] carry
);

   localparam int NST = N - 1;

   logic [W-1:0] s_st [NST];
   logic [W-1:0] c_st [NST];

   assign s_st[0] = rows[0];
   assign c_st[0] = rows[1];

   // linear chain of 3:2 compressors, one per extra row
   for (genvar j = 0; j < N-2; j++) begin : g_stage
      logic [W-1:0] a, b, c, maj;
      assign a   = s_st[j];
      assign b   = c_st[j];
      assign c   = rows[j+2];
      assign maj = (a & b) | (a & c) | (b & c);
      assign s_st[j+1] = a ^ b ^ c;
      assign c_st[j+1] = {maj[W-2:0], 1'b0};
   end

   assign sum   = s_st[NST-1];
   assign carry = c_st[NST-1];

endmodule

// File: rtl/booth_mac.sv
`timescale 1ns/1ps
module booth_mac
   import booth_mac_pkg::*;
#(
   parameter int OPW  = 8,
   parameter int ACCW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            in_valid,
   input  logic            is_signed,
   input  logic [OPW-1:0]  x,
   input  logic [OPW-1:0]  y,
   output logic [ACCW-1:0] acc_out
);

   localparam int NDIG  = OPW/2 + 1;
   localparam int NROWS = NDIG + 2;

   // elaboration-time parameter checks
   if ((OPW % 2) != 0 || OPW < 4) begin : g_bad_opw
      $error("booth_mac: OPW must be even and at least 4");
   end
   if (ACCW < 2*OPW) begin : g_bad_accw
      $error("booth_mac: ACCW must hold a full product");
   end

   booth_sel_t      sel [NDIG];
   logic [ACCW-1:0] mcand;
   logic [ACCW-1:0] rows [NROWS];
   logic [ACCW-1:0] cin_row;
   logic [ACCW-1:0] sum_row, carry_row, next_acc;
   logic [ACCW-1:0] acc_q;

   assign mcand = {{(ACCW-OPW){is_signed & x[OPW-1]}}, x};

   booth_recoder #(.OPW(OPW), .NDIG(NDIG)) u_rec (
      .mplier    (y),
      .is_signed (is_signed),
      .sel       (sel)
   );

   for (genvar k = 0; k < NDIG; k++) begin : g_pp
      booth_pp_row #(.ACCW(ACCW), .SHIFT(2*k)) u_row (
         .mcand (mcand),
         .sel   (sel[k]),
         .row   (rows[k])
      );
   end

   // +1 of each negated digit at its lowest weight; positions never collide
   always_comb begin
      cin_row = '0;
      for (int k = 0; k < NDIG; k++)
         cin_row[2*k] = sel[k].neg;
   end

   assign rows[NDIG]   = cin_row;
   assign rows[NDIG+1] = acc_q;

   csa_reduce #(.W(ACCW), .N(NROWS)) u_csa (
      .rows  (rows),
      .sum   (sum_row),
      .carry (carry_row)
   );

   // the single carry-propagate adder
   assign next_acc = sum_row + carry_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr)
         acc_q <= '0;
      else if (in_valid)
         acc_q <= next_acc;
   end

   assign acc_out = acc_q;

endmodule

// File: rtl/booth_mac_chk.sv
`timescale 1ns/1ps
module booth_mac_chk #(
   parameter int OPW  = 8,
   parameter int ACCW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            clr,
   input logic            in_valid,
   input logic            is_signed,
   input logic [OPW-1:0]  x,
   input logic [OPW-1:0]  y,
   input logic [ACCW-1:0] acc_out
);

   function automatic logic [ACCW-1:0] ref_prod(input logic [OPW-1:0] a,
                                                input logic [OPW-1:0] b,
                                                input logic           s);
      logic [ACCW-1:0] ea, eb;
      ea = {{(ACCW-OPW){s & a[OPW-1]}}, a};
      eb = {{(ACCW-OPW){s & b[OPW-1]}}, b};
      return ea * eb;
   endfunction

   // R1 R2 R3 R4 R8: accepted operation adds the exact product, wrapping
   p_accumulate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clr) |=> acc_out == $past(acc_out) + ref_prod($past(x), $past(y), $past(is_signed)));

   // R5: clear wins over valid
   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc_out == '0);

   // R6: idle edge holds the total
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !in_valid) |=> $stable(acc_out));

   // R9: zero operand adds nothing
   p_zero_operand_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clr && (x == '0 || y == '0)) |=> $stable(acc_out));

endmodule

bind booth_mac booth_mac_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .in_valid  (in_valid),
   .is_signed (is_signed),
   .x         (x),
   .y         (y),
   .acc_out   (acc_out)
);

// File: tb/booth_mac_tb.sv
`timescale 1ns/1ps
module booth_mac_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_signed = 1'b0;
   logic [7:0]  x = '0;
   logic [7:0]  y = '0;
   logic [15:0] acc_out;

   logic [15:0] model = '0;
   int          n_checks = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   booth_mac u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .is_signed(is_signed), .x(x), .y(y), .acc_out(acc_out)
   );

   function automatic logic [15:0] prod(input logic [7:0] a, input logic [7:0] b, input logic s);
      int ia, ib;
      ia = s ? int'($signed(a)) : int'(a);
      ib = s ? int'($signed(b)) : int'(b);
      return 16'(ia * ib);
   endfunction

   task automatic check(input logic [15:0] exp, input string tag);
      n_checks++;
      if (acc_out !== exp) begin
         n_fail++;
         $display("FAIL %s: acc_out=%h expected %h", tag, acc_out, exp);
      end
   endtask

   // drive at falling edge, result due at the next rising edge
   task automatic step(input logic [7:0] a, input logic [7:0] b, input logic s,
                       input logic v, input logic c, input string tag);
      @(negedge clk);
      x = a; y = b; is_signed = s; in_valid = v; clr = c;
      if (c)      model = '0;
      else if (v) model = model + prod(a, b, s);
      @(posedge clk);
      #2;
      check(model, tag);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: acc_out=%h expected run to finish", acc_out);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #35;
      n_checks++;
      if (acc_out !== 16'h0) begin
         n_fail++;
         $display("FAIL R7 in reset: acc_out=%h expected 0000", acc_out);
      end
      @(negedge clk); rst_n = 1'b1;
      step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, "R7 after release");

      step(8'd2, 8'd4, 1'b0, 1'b1, 1'b0, "R1 2x4");
      step(8'h80, 8'h80, 1'b1, 1'b1, 1'b1, "R5 clear with valid");
      step(8'h80, 8'h80, 1'b1, 1'b1, 1'b0, "R2 -128x-128");
      step(8'h80, 8'h7F, 1'b1, 1'b1, 1'b0, "R2 -128x127");
      step(8'h7F, 8'h7F, 1'b1, 1'b1, 1'b0, "R2 127x127");
      step(8'hFF, 8'h02, 1'b1, 1'b1, 1'b0, "R2 -1x2");
      step(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, "R5 clear");
      step(8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, "R3 255x255");
      step(8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, "R8 wrap 255x255 twice");
      step(8'h80, 8'hFF, 1'b0, 1'b1, 1'b0, "R3 128x255");
      step(8'h5A, 8'h33, 1'b1, 1'b0, 1'b0, "R6 idle hold");
      step(8'hC3, 8'h7E, 1'b0, 1'b0, 1'b0, "R6 idle hold unsigned");
      step(8'h00, 8'hA7, 1'b1, 1'b1, 1'b0, "R9 x zero");
      step(8'h91, 8'h00, 1'b0, 1'b1, 1'b0, "R9 y zero");

      // R4: multiplier patterns covering every recoding window
      foreach (y_pat[i]) begin
         step(8'h6D, y_pat[i], 1'b0, 1'b1, 1'b0, "R4 unsigned pattern");
         step(8'hB7, y_pat[i], 1'b1, 1'b1, 1'b0, "R4 signed pattern");
      end

      // random mix with corner operands
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a, b;
         logic       s, v, c;
         a = 8'($urandom);
         b = 8'($urandom);
         case ($urandom % 8)
            0: a = 8'h80;
            1: b = 8'h7F;
            2: a = 8'hFF;
            3: b = 8'h00;
            default: ;
         endcase
         s = 1'($urandom);
         v = ($urandom % 4) != 0;
         c = ($urandom % 32) == 0;
         step(a, b, s, v, c, "R1 R2 R3 R8 random");
      end

      @(negedge clk);
      in_valid = 1'b0; clr = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   logic [7:0] y_pat [10] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F,
                              8'hF0, 8'h01, 8'h80, 8'h6B, 8'h94};

endmodule